// File: doc/BRIEF.md
# Double-Buffered Quad Converter Register Interface

This block is the digital register front end of a four-channel converter. A host drives a 12-bit parallel bus, a 2-bit channel address and three active-low strobes: chip select (`csN`), load (`lsN`) and mode select (`msN`). Each channel has two 12-bit data registers. The input rank collects new codes. The output rank holds the codes the converters are using at the moment. An 8-bit mode register, also held in two ranks, sets a gain bit and a polarity bit for every channel.

All strobes are sampled on the system clock, and the block acts on the falling edge of `csN` and the rising edge of `lsN`. The relative order of these two edges decides what a cycle does. It can load the input rank only, which is a preload. It can load the input rank and then commit it, which is a load-and-update. It can commit the input rank with no new data, which is an update-only cycle. Two pass-through settings on `xpar` skip the input rank. One of them passes the bus straight to the addressed channel's output register. The other passes it to all four channels.

Top module: `quad_dac_regif`

## Requirements
- R1: During reset and after its release, every input-rank and output-rank register reads zero. All codes are zero, all gain bits are 0 (gain 1) and all polarity bits are 0 (unipolar).
- R2: With `msN` high, `lsN` low and `xpar`=00, a clock that sees `csN` fall stores `dataIn` in the input rank of the channel selected by `addr`. No output changes unless `lsN` later rises while `csN` is still low. Outputs change only on clocks where `csN` is low.
- R3: With `msN` high and `xpar`=00, a rising `lsN` seen while `csN` is low copies all four input-rank data registers into the output rank (load-and-update).
- R4: With `msN` high and `xpar`=00, a falling `csN` seen while `lsN` is high copies all four input-rank data registers into the output rank and loads no new data (update-only).
- R5: With `msN` low and `lsN` low, a falling `csN` stores `dataIn[11:4]` in the input-rank mode register and ignores `dataIn[3:0]`. If `csN` rises before `lsN` does, the active modes stay as they were (preload).
- R6: With `msN` low, a rising `lsN` while `csN` is low, or a falling `csN` while `lsN` is high, copies the whole input-rank mode register to the output rank. The gain bit of channel i is mode bit 4+i, which is `dataIn` bit 8+i, and 1 means gain 2. The polarity bit of channel i is mode bit i, which is `dataIn` bit 4+i, and 1 means bipolar. Mode cycles never change data registers.
- R7: With `xpar`=01, `msN` high, and both `csN` and `lsN` low, every clock writes `dataIn` into the output register of the addressed channel. The other channels' output registers do not change, and no input-rank register changes.
- R8: With `xpar`=10 or 11, `msN` high, and both `csN` and `lsN` low, every clock writes `dataIn` into all four output registers. While `xpar` is nonzero, data loads and data commits through the input rank are suppressed.
- R9: `rdData` returns the output-rank code of the addressed channel while `rdEn` is high and `csN` is low. Otherwise it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select strobe, active low |
| lsN | input | 1 | Load strobe, active low |
| msN | input | 1 | Mode select, low for mode cycles |
| addr | input | 2 | Channel address |
| dataIn | input | 12 | Parallel bus word |
| xpar | input | 2 | Pass-through setting: 00 off, 01 one channel, 1x all channels |
| rdEn | input | 1 | Readback enable |
| rdData | output | 12 | Readback of the addressed output-rank code |
| chanData | output | 48 | Output-rank codes, channel i at bits 12*i+11 : 12*i |
| gainSel | output | 4 | Output-rank gain bit per channel, 1 = gain 2 |
| bipolar | output | 4 | Output-rank polarity bit per channel, 1 = bipolar |

## Verification
A bad input-rank register does not show at the ports until the next commit. So every preload is followed by an update-only cycle, and the outputs are compared one clock after that cycle. An edge detector that fires on the wrong level or too late shows up as an output-rank change on a clock where `csN` is high, or as a lost commit. Both are visible at the next sample. Pass-through faults show within one clock as a wrong value on the addressed channel or on a channel that should not have changed. Running an update-only cycle after a pass-through shows whether the input rank was disturbed.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  // Strobes from the control unit to the register datapath.
  typedef struct packed {
    logic ldData;   // store bus into addressed input-rank data register
    logic cmData;   // copy all input-rank data into output rank
    logic ldMode;   // store bus upper bits into input-rank mode register
    logic cmMode;   // copy input-rank mode into output rank
    logic passOne;  // bus straight to addressed output register
    logic passAll;  // bus straight to every output register
  } strobe_t;
endpackage

// File: rtl/qdac_ctrl.sv
module qdac_ctrl
  import qdac_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       lsN,
  input  logic       msN,
  input  logic [1:0] xpar,
  output strobe_t    stb
);
  logic prevCs, prevLs;
  logic csFall, lsRise, xparOn, dataWin;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevCs <= 1'b1;
      prevLs <= 1'b1;
    end else begin
      prevCs <= csN;
      prevLs <= lsN;
    end
  end

  always_comb begin
    csFall  = prevCs & ~csN;
    lsRise  = ~prevLs & lsN;
    xparOn  = |xpar;
    dataWin = msN & ~csN & ~lsN;

    stb.passAll = dataWin & xpar[1];
    stb.passOne = dataWin & (xpar == 2'b01);
    stb.ldData  = msN & ~xparOn & csFall & ~lsN;
    stb.cmData  = msN & ~xparOn & ((lsRise & ~csN) | (csFall & lsN));
    stb.ldMode  = ~msN & csFall & ~lsN;
    stb.cmMode  = ~msN & ((lsRise & ~csN) | (csFall & lsN));
  end
endmodule

// File: rtl/qdac_dpath.sv
module qdac_dpath
  import qdac_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  stb,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        dataIn,
  input  logic                     rdEn,
  input  logic                     csN,
  output logic [DATA_W-1:0]        rdData,
  output logic [NUM_CH*DATA_W-1:0] chanData,
  output logic [NUM_CH-1:0]        gainSel,
  output logic [NUM_CH-1:0]        bipolar
);
  localparam int MODE_W = 2 * NUM_CH;

  logic [DATA_W-1:0] rankIn  [NUM_CH];
  logic [DATA_W-1:0] rankOut [NUM_CH];
  logic [MODE_W-1:0] modeIn, modeOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int ch = 0; ch < NUM_CH; ch++) begin
        rankIn[ch]  <= '0;
        rankOut[ch] <= '0;
      end
    end else begin
      for (int ch = 0; ch < NUM_CH; ch++) begin
        if (stb.ldData && addr == ADDR_W'(ch)) rankIn[ch] <= dataIn;
        if (stb.cmData)
          rankOut[ch] <= rankIn[ch];
        else if (stb.passAll || (stb.passOne && addr == ADDR_W'(ch)))
          rankOut[ch] <= dataIn;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeIn  <= '0;
      modeOut <= '0;
    end else begin
      if (stb.ldMode) modeIn  <= dataIn[DATA_W-1 -: MODE_W];
      if (stb.cmMode) modeOut <= modeIn;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_out
    assign chanData[g*DATA_W +: DATA_W] = rankOut[g];
  end

  assign gainSel = modeOut[MODE_W-1 -: NUM_CH];
  assign bipolar = modeOut[NUM_CH-1:0];
  assign rdData  = (rdEn && !csN) ? rankOut[addr] : '0;
endmodule

// File: rtl/quad_dac_regif.sv
module quad_dac_regif
  import qdac_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int NUM_CH = 4,
  localparam int ADDR_W = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     csN,
  input  logic                     lsN,
  input  logic                     msN,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        dataIn,
  input  logic [1:0]               xpar,
  input  logic                     rdEn,
  output logic [DATA_W-1:0]        rdData,
  output logic [NUM_CH*DATA_W-1:0] chanData,
  output logic [NUM_CH-1:0]        gainSel,
  output logic [NUM_CH-1:0]        bipolar
);
  strobe_t stb;

  qdac_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .lsN(lsN), .msN(msN),
    .xpar(xpar), .stb(stb)
  );

  qdac_dpath #(.DATA_W(DATA_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .addr(addr), .dataIn(dataIn),
    .rdEn(rdEn), .csN(csN), .rdData(rdData), .chanData(chanData),
    .gainSel(gainSel), .bipolar(bipolar)
  );
endmodule

// File: rtl/quad_dac_regif_chk.sv
module quad_dac_regif_chk #(
  parameter int DATA_W = 12,
  parameter int NUM_CH = 4,
  localparam int ADDR_W = $clog2(NUM_CH)
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     csN,
  input logic                     lsN,
  input logic                     msN,
  input logic [ADDR_W-1:0]        addr,
  input logic [DATA_W-1:0]        dataIn,
  input logic [1:0]               xpar,
  input logic                     rdEn,
  input logic [DATA_W-1:0]        rdData,
  input logic [NUM_CH*DATA_W-1:0] chanData,
  input logic [NUM_CH-1:0]        gainSel,
  input logic [NUM_CH-1:0]        bipolar
);
  // R1: reset clears all outputs
  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |=> (chanData == '0 && gainSel == '0 && bipolar == '0));

  // R2 / R6: nothing in the output rank moves on a clock with csN high
  a_r2_hold_when_deselected: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> ($stable(chanData) && $stable(gainSel) && $stable(bipolar)));

  // R6: mode cycles leave data untouched
  a_r6_mode_no_data: assert property (@(posedge clk) disable iff (!rstN)
    !msN |=> $stable(chanData));

  // R8: full pass-through drives the bus to all channels
  a_r8_pass_all: assert property (@(posedge clk) disable iff (!rstN)
    (msN && !csN && !lsN && xpar[1]) |=> (chanData == {NUM_CH{$past(dataIn)}}));

  // R9: readback gating and selection
  a_r9_read_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!rdEn || csN) |-> (rdData == '0));
  a_r9_read_sel: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !csN) |-> (rdData == chanData[addr*DATA_W +: DATA_W]));
endmodule

bind quad_dac_regif quad_dac_regif_chk #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/quad_dac_regif_tb.sv
module quad_dac_regif_tb;
  logic        clk = 1'b0;
  logic        rstN, csN, lsN, msN, rdEn;
  logic [1:0]  addr, xpar;
  logic [11:0] dataIn, rdData;
  logic [47:0] chanData;
  logic [3:0]  gainSel, bipolar;

  int nChk = 0;
  int nBad = 0;
  logic [11:0] e1 [4];
  logic [11:0] e2 [4];
  logic [7:0]  m1, m2;

  always #5 clk = ~clk;

  quad_dac_regif u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .lsN(lsN), .msN(msN), .addr(addr),
    .dataIn(dataIn), .xpar(xpar), .rdEn(rdEn), .rdData(rdData),
    .chanData(chanData), .gainSel(gainSel), .bipolar(bipolar)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic checkAll(string req);
    for (int ch = 0; ch < 4; ch++) begin
      nChk++;
      if (chanData[ch*12 +: 12] !== e2[ch]) begin
        nBad++;
        $display("FAIL %s ch%0d code: actual %h expected %h", req, ch, chanData[ch*12 +: 12], e2[ch]);
      end
    end
    nChk++;
    if (gainSel !== m2[7:4] || bipolar !== m2[3:0]) begin
      nBad++;
      $display("FAIL %s mode: actual gain %b pol %b expected gain %b pol %b",
               req, gainSel, bipolar, m2[7:4], m2[3:0]);
    end
  endtask

  task automatic checkRd(string req, logic [11:0] exp);
    nChk++;
    if (rdData !== exp) begin
      nBad++;
      $display("FAIL %s readback: actual %h expected %h", req, rdData, exp);
    end
  endtask

  // R2 preload of one data channel
  task automatic preloadData(int ch, logic [11:0] v);
    msN = 1; lsN = 0; addr = 2'(ch); dataIn = v; step();
    csN = 0; step();
    csN = 1; step();
    lsN = 1; step();
    e1[ch] = v;
  endtask

  // R4 update-only
  task automatic updateData();
    msN = 1; lsN = 1; step();
    csN = 0; step();
    csN = 1; step();
    for (int ch = 0; ch < 4; ch++) e2[ch] = e1[ch];
  endtask

  // R3 load-and-update
  task automatic loadUpdate(int ch, logic [11:0] v);
    msN = 1; lsN = 0; addr = 2'(ch); dataIn = v; step();
    csN = 0; step();
    lsN = 1; step();
    csN = 1; step();
    e1[ch] = v;
    for (int c = 0; c < 4; c++) e2[c] = e1[c];
  endtask

  task automatic modeCycle(logic [7:0] w, bit commit);
    msN = 0; lsN = 0; dataIn = {w, 4'hF}; step();
    csN = 0; step();
    if (commit) begin lsN = 1; step(); csN = 1; step(); end
    else begin csN = 1; step(); lsN = 1; step(); end
    msN = 1; step();
    m1 = w;
    if (commit) m2 = w;
  endtask

  task automatic modeUpdate();
    msN = 0; lsN = 1; step();
    csN = 0; step();
    csN = 1; step();
    msN = 1; step();
    m2 = m1;
  endtask

  initial begin : watchdog
    #2_000_000;
    nChk++; nBad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    rstN = 0; csN = 1; lsN = 1; msN = 1; rdEn = 0; addr = 0; xpar = 0; dataIn = 0;
    for (int ch = 0; ch < 4; ch++) begin e1[ch] = 0; e2[ch] = 0; end
    m1 = 0; m2 = 0;
    step(); step();
    checkAll("R1 in reset");
    rstN = 1; step(); step();
    checkAll("R1 after reset");

    // Data sweep: preload, verify hold, then update-only
    for (int ch = 0; ch < 4; ch++) begin
      for (int k = 0; k < 3; k++) begin
        preloadData(ch, 12'((ch * 12'h311 + k * 12'h0A7 + 12'h005) & 12'hFFF));
        checkAll("R2 preload holds outputs");
      end
      updateData();
      checkAll("R4 update-only commit");
    end

    // R9 readback over all channels
    csN = 0; rdEn = 1; step();
    for (int ch = 0; ch < 4; ch++) begin
      addr = 2'(ch); step();
      checkRd("R9 read", e2[ch]);
    end
    rdEn = 0; step();
    checkRd("R9 rdEn low", 12'h000);
    csN = 1; rdEn = 1; step();
    checkRd("R9 cs high", 12'h000);
    rdEn = 0; step();

    // R3 load-and-update, each channel with edge codes
    for (int ch = 0; ch < 4; ch++) begin
      loadUpdate(ch, (ch % 2 == 0) ? 12'hFFF : 12'h800 + 12'(ch));
      checkAll("R3 load-and-update");
    end

    // Mode: preload, update-only, load-and-update
    for (int b = 0; b < 8; b++) begin
      modeCycle(8'(1 << b), 1'b0);
      checkAll("R5 mode preload keeps active mode");
      modeUpdate();
      checkAll("R6 mode update-only");
    end
    modeCycle(8'hA5, 1'b1);
    checkAll("R6 mode load-and-update");
    modeCycle(8'h3C, 1'b1);
    checkAll("R6 mode load-and-update 2");

    // R7 partial pass-through on channel 2
    xpar = 2'b01; msN = 1; lsN = 0; addr = 2'd2; dataIn = 12'h5A5; step();
    csN = 0; step();
    e2[2] = 12'h5A5; checkAll("R7 partial first word");
    dataIn = 12'h1C3; step();
    e2[2] = 12'h1C3; checkAll("R7 partial follows bus");
    csN = 1; step();
    lsN = 1; step();
    checkAll("R7 partial held after release");
    xpar = 2'b00; updateData();
    checkAll("R7 input rank untouched");

    // R8 full pass-through with both encodings
    for (int x = 2; x < 4; x++) begin
      xpar = 2'(x); msN = 1; lsN = 0; addr = 2'd1; dataIn = 12'h0F0 + 12'(x); step();
      csN = 0; step();
      for (int ch = 0; ch < 4; ch++) e2[ch] = 12'h0F0 + 12'(x);
      checkAll("R8 full pass-through");
      lsN = 1; step();
      checkAll("R8 no commit while transparent");
      csN = 1; step();
      xpar = 2'b00; updateData();
      checkAll("R8 input rank untouched");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule